// File: doc/BRIEF.md
# Conversion Sequencer with Sync Control

This block frames the conversion periods of a delta-sigma style converter. It counts the ones arriving on a one-bit modulator stream over a programmable number of samples to form a partial result. At the close of each period it adds that partial result to the two partial results kept from the previous periods. The sum goes into an output register, and a one-cycle ready pulse announces it. The new value replaces the old one whether or not the old one was consumed.

A synchronization request restarts the sample count of the current period and drops the samples gathered in that period so far. It can come from a level-sensitive pin, passed through two flops, or from a single-clock command strobe. The two kept partial results are not touched, so they still take part in the following sums. A side effect is that the period in which the request lands runs longer than usual.

A channel-change strobe tells the block that the analog input has moved. A settling tracker then holds the valid flag low until the history no longer contains mixed data. That takes four conversions without a sync, and three when a sync follows the change before the current period closes.

Top module: `cnvseq_top`

## Requirements
- R1: `dout` changes only on the clock edge that ends a cycle in which `drdy` is high. Each new sum replaces the previous one unconditionally.
- R2: `drdy` rises on the edge that ends a period and stays high for exactly one cycle. During that cycle `dout` still shows the previous sum.
- R3: A period is max(`conv_len`, 2) samples long, one sample per clock. A partial result is the number of ones on `mod_bit` over that period.
- R4: The published sum is the partial result just finished plus the two partial results from the two periods before it. Both kept values are zero after reset.
- R5: A high on `sync_cmd`, or on `sync_pin` after its two-flop delay, sets the sample count and the ones count to zero. While `sync_pin` is held high, no period ends. After `sync_pin` is released, the next `drdy` appears max(`conv_len`,2)+2 cycles later.
- R6: A sync request leaves both kept partial results unchanged. With a constant input, the sum after a sync equals the sum before it.
- R7: If a sync request coincides with the last sample of a period, the sync takes priority: no sum is published and the count restarts. The gap between `drdy` pulses becomes 2·max(`conv_len`,2).
- R8: If a sync request lands when k samples of the period have been taken, the gap between `drdy` pulses becomes max(`conv_len`,2)+k+1 cycles.
- R9: After `chan_chg` with no following sync, `valid` goes low and rises only with the fourth published sum.
- R10: After `chan_chg` followed by a sync before the period ends (or in the same clock), `valid` rises with the third published sum.
- R11: Under reset, `dout`, `drdy` and `valid` are zero. After reset, `valid` rises with the third published sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator output bit, one sample per clock |
| sync_pin | input | 1 | Asynchronous level sync request |
| sync_cmd | input | 1 | Single-clock sync command strobe |
| chan_chg | input | 1 | Single-clock strobe: input channel changed |
| conv_len | input | LEN_W | Samples per period (values below 2 act as 2) |
| dout | output | LEN_W+2 | Published conversion sum |
| drdy | output | 1 | One-cycle pulse ahead of a `dout` update |
| valid | output | 1 | Published sum holds settled data only |

## Verification
The hardest situations to reach are a sync strobe that lands exactly on the last sample of a period, and a channel change followed by a sync before the current period closes. Neither is visible at the ports until the next `drdy`. The stimulus lines up on an observed `drdy` pulse and counts clocks from it, so a strobe can be placed at a chosen sample index k, including k = length−1. It then measures the gap to the next pulse and counts published sums until `valid` rises. A random phase with occasional strobes, pin pulses and length changes then runs against a cycle model in the bench.

// File: rtl/cnvseq_pkg.sv
package cnvseq_pkg;

    // number of past partial results folded into every sum
    localparam int HIST_D      = 2;
    // flops on the asynchronous sync input
    localparam int SYNC_STAGES = 2;

    localparam int SET_W = 3;
    localparam logic [SET_W-1:0] SET_CHG  = 3'd4;  // change, no sync
    localparam logic [SET_W-1:0] SET_SYNC = 3'd3;  // change then sync
    localparam logic [SET_W-1:0] SET_RST  = 3'd3;  // history empty

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_SYNC = 2'd1,
        EV_END  = 2'd2
    } frame_ev_e;

    typedef struct packed {
        logic [SET_W-1:0] left;   // conversions still to settle
        logic             mixed;  // current period holds old-channel data
    } settle_t;

    function automatic settle_t settle_step(settle_t cur, logic chg,
                                            logic sreq, logic fin);
        settle_t nxt = cur;
        if (chg) begin
            nxt.left  = sreq ? SET_SYNC : SET_CHG;
            nxt.mixed = !sreq;
        end else if (sreq && cur.mixed) begin
            nxt.left  = SET_SYNC;
            nxt.mixed = 1'b0;
        end else if (fin) begin
            nxt.mixed = 1'b0;
            if (cur.left != '0) nxt.left = SET_W'(cur.left - 1'b1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cnvseq_sync2.sv
module cnvseq_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/cnvseq_frame.sv
module cnvseq_frame
    import cnvseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit,
    input  logic             sync_req,
    input  logic [LEN_W-1:0] conv_len,
    output frame_ev_e        ev,
    output logic [LEN_W:0]   part
);
    localparam int ACC_W = LEN_W + 1;

    logic [LEN_W-1:0] cnt;
    logic [ACC_W-1:0] acc;
    logic [LEN_W-1:0] last_idx;

    // periods shorter than two samples are widened to two
    always_comb begin
        if (conv_len < LEN_W'(2)) last_idx = LEN_W'(1);
        else                      last_idx = conv_len - 1'b1;
    end

    always_comb begin
        part = acc + ACC_W'(mod_bit);
        if (sync_req)             ev = EV_SYNC;
        else if (cnt >= last_idx) ev = EV_END;
        else                      ev = EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            acc <= '0;
        end else begin
            case (ev)
                EV_NONE: begin
                    cnt <= cnt + 1'b1;
                    acc <= part;
                end
                default: begin
                    cnt <= '0;
                    acc <= '0;
                end
            endcase
        end
    end

    p_sync_clear_r5: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> (cnt == '0 && acc == '0));

    p_end_resets_r3: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_END) |=> (cnt == '0));
endmodule

// File: rtl/cnvseq_hist.sv
module cnvseq_hist
    import cnvseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_ev_e        ev,
    input  logic [LEN_W:0]   part,
    output logic [LEN_W+1:0] dout,
    output logic             drdy
);
    localparam int RES_W = LEN_W + 2;

    logic [HIST_D-1:0][LEN_W:0] hist;
    logic [RES_W-1:0]           sum;
    logic [RES_W-1:0]           pend;

    always_comb begin
        sum = RES_W'(part);
        for (int i = 0; i < HIST_D; i++) sum = sum + RES_W'(hist[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)                hist[0] <= '0;
        else if (ev == EV_END)  hist[0] <= part;
    end

    for (genvar g = 1; g < HIST_D; g++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst)               hist[g] <= '0;
            else if (ev == EV_END) hist[g] <= hist[g-1];
        end
    end

    // flag rises first, register follows on the next edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            dout <= '0;
            drdy <= 1'b0;
        end else begin
            drdy <= (ev == EV_END);
            if (ev == EV_END) pend <= sum;
            if (drdy)         dout <= pend;
        end
    end

    p_drdy_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        drdy |=> !drdy);

    p_dout_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !drdy |=> $stable(dout));

    p_hist_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (ev != EV_END) |=> $stable(hist));
endmodule

// File: rtl/cnvseq_valid.sv
module cnvseq_valid
    import cnvseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  frame_ev_e ev,
    input  logic      chan_chg,
    input  logic      drdy,
    output logic      valid
);
    settle_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '{left: SET_RST, mixed: 1'b0};
            valid <= 1'b0;
        end else begin
            st <= settle_step(st, chan_chg, ev == EV_SYNC, ev == EV_END);
            if (chan_chg)  valid <= 1'b0;
            else if (drdy) valid <= (st.left == '0);
        end
    end

    p_chg_clears_r9: assert property (@(posedge clk) disable iff (rst)
        chan_chg |=> !valid);

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(drdy));
endmodule

// File: rtl/cnvseq_top.sv
module cnvseq_top
    import cnvseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_bit,
    input  logic             sync_pin,
    input  logic             sync_cmd,
    input  logic             chan_chg,
    input  logic [LEN_W-1:0] conv_len,
    output logic [LEN_W+1:0] dout,
    output logic             drdy,
    output logic             valid
);
    logic           pin_s;
    logic           sync_req;
    frame_ev_e      ev;
    logic [LEN_W:0] part;

    cnvseq_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_pin),
        .q   (pin_s)
    );

    assign sync_req = pin_s | sync_cmd;

    cnvseq_frame #(.LEN_W(LEN_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .mod_bit  (mod_bit),
        .sync_req (sync_req),
        .conv_len (conv_len),
        .ev       (ev),
        .part     (part)
    );

    cnvseq_hist #(.LEN_W(LEN_W)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .part (part),
        .dout (dout),
        .drdy (drdy)
    );

    cnvseq_valid u_valid (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .chan_chg (chan_chg),
        .drdy     (drdy),
        .valid    (valid)
    );

    p_sync_wins_r7: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> !drdy);
endmodule

// File: tb/test_cnvseq_top.sv
module test_cnvseq_top;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mod_bit = 1'b0;
    logic             sync_pin = 1'b0;
    logic             sync_cmd = 1'b0;
    logic             chan_chg = 1'b0;
    logic [LEN_W-1:0] conv_len = 8'd4;
    logic [LEN_W+1:0] dout;
    logic             drdy;
    logic             valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    cnvseq_top #(.LEN_W(LEN_W)) i_cnvseq_top (
        .clk(clk), .rst(rst), .mod_bit(mod_bit), .sync_pin(sync_pin),
        .sync_cmd(sync_cmd), .chan_chg(chan_chg), .conv_len(conv_len),
        .dout(dout), .drdy(drdy), .valid(valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- cycle model built from the requirements ----------------
    int m_s1, m_s2, m_cnt, m_acc, m_h0, m_h1, m_pend, m_dout, m_set;
    bit m_drdy, m_mix, m_val;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_cnt <= 0; m_acc <= 0; m_h0 <= 0; m_h1 <= 0;
            m_pend <= 0; m_dout <= 0; m_drdy <= 0; m_set <= 3; m_mix <= 0; m_val <= 0;
        end else begin : m_step
            automatic bit sreq = (m_s2 != 0) || sync_cmd;
            automatic int len  = (conv_len < 2) ? 2 : int'(conv_len);
            automatic bit fin  = !sreq && (m_cnt >= len - 1);
            automatic int part = m_acc + int'(mod_bit);
            m_s1 <= int'(sync_pin);
            m_s2 <= m_s1;
            if (sreq) begin
                m_cnt <= 0; m_acc <= 0;
            end else if (fin) begin
                m_cnt <= 0; m_acc <= 0;
                m_h0 <= part; m_h1 <= m_h0; m_pend <= part + m_h0 + m_h1;
            end else begin
                m_cnt <= m_cnt + 1; m_acc <= part;
            end
            m_drdy <= fin;
            if (m_drdy) m_dout <= m_pend;
            if (chan_chg) begin
                m_set <= sreq ? 3 : 4; m_mix <= !sreq;
            end else if (sreq && m_mix) begin
                m_set <= 3; m_mix <= 0;
            end else if (fin) begin
                m_mix <= 0; if (m_set > 0) m_set <= m_set - 1;
            end
            if (chan_chg)    m_val <= 0;
            else if (m_drdy) m_val <= (m_set == 0);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(int'(dout) == m_dout, "R1 R3 R4 dout vs model", int'(dout), m_dout);
            chk(drdy == m_drdy, "R2 drdy vs model", int'(drdy), int'(m_drdy));
            chk(valid == m_val, "R9 R10 valid vs model", int'(valid), int'(m_val));
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_drdy();
        do @(negedge clk); while (!drdy);
    endtask

    task automatic loads_until_valid(output int n);
        n = 0;
        do begin
            wait_drdy();
            tick(1);
            n++;
        end while (!valid && n < 8);
    endtask

    task automatic sync_gap(input int k, output int gap);
        wait_drdy();
        tick(k);
        sync_cmd = 1'b1;
        tick(1);
        sync_cmd = 1'b0;
        gap = k + 1;
        while (!drdy) begin
            tick(1);
            gap++;
        end
    endtask

    task automatic plain_gap(output int gap);
        wait_drdy();
        gap = 0;
        do begin
            tick(1);
            gap++;
        end while (!drdy);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int n;
        int seen;
        int exp_seq [3] = '{8, 4, 0};
        void'($urandom(32'd5150));
        tick(3);
        // R11 reset state
        chk(dout == 0 && drdy == 0 && valid == 0, "R11 reset outputs",
            int'({dout, drdy, valid}), 0);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R11 valid after third sum, steady all-ones input
        mod_bit = 1'b1;
        loads_until_valid(n);
        chk(n == 3, "R11 loads until valid after reset", n, 3);
        chk(dout == 12, "R4 sum of three full partials", int'(dout), 12);

        // R4 zeros from a period boundary: 0+4+4, 0+0+4, 0
        wait_drdy();
        mod_bit = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wait_drdy();
            tick(1);
            chk(int'(dout) == exp_seq[i], "R4 history sum sequence", int'(dout), exp_seq[i]);
        end

        // refill with ones, then sync mid period: R8 gap and R6 history kept
        wait_drdy();
        mod_bit = 1'b1;
        repeat (3) wait_drdy();
        sync_gap(2, n);
        chk(n == 4 + 2 + 1, "R8 stretched gap k=2", n, 7);
        tick(1);
        chk(dout == 12, "R6 history survives sync", int'(dout), 12);
        sync_gap(0, n);
        chk(n == 4 + 0 + 1, "R8 stretched gap k=0", n, 5);

        // R7 sync on the last sample of a period
        sync_gap(3, n);
        chk(n == 8, "R7 sync wins over period end", n, 8);

        // R5 pin held: no period ends; release latency len+2
        wait_drdy();
        sync_pin = 1'b1;
        seen = 0;
        for (int i = 0; i < 14; i++) begin
            tick(1);
            if (drdy) seen++;
        end
        chk(seen == 0, "R5 no drdy while pin held", seen, 0);
        sync_pin = 1'b0;
        n = 0;
        do begin
            tick(1);
            n++;
        end while (!drdy && n < 40);
        chk(n == 6, "R5 release to drdy latency", n, 6);

        // R9 channel change without sync
        wait_drdy();
        chan_chg = 1'b1;
        tick(1);
        chan_chg = 1'b0;
        chk(valid == 0, "R9 valid drops on change", int'(valid), 0);
        loads_until_valid(n);
        chk(n == 4, "R9 four conversions to valid", n, 4);

        // R10 change then sync in the next clock
        wait_drdy();
        chan_chg = 1'b1;
        tick(1);
        chan_chg = 1'b0;
        sync_cmd = 1'b1;
        tick(1);
        sync_cmd = 1'b0;
        loads_until_valid(n);
        chk(n == 3, "R10 change then sync settles in three", n, 3);

        // R10 change and sync in the same clock
        wait_drdy();
        chan_chg = 1'b1;
        sync_cmd = 1'b1;
        tick(1);
        chan_chg = 1'b0;
        sync_cmd = 1'b0;
        loads_until_valid(n);
        chk(n == 3, "R10 same-clock change and sync", n, 3);

        // R3 length floor and a longer length
        wait_drdy();
        conv_len = 8'd0;
        plain_gap(n);
        chk(n == 2, "R3 length zero acts as two", n, 2);
        conv_len = 8'd1;
        plain_gap(n);
        chk(n == 2, "R3 length one acts as two", n, 2);
        wait_drdy();
        conv_len = 8'd7;
        plain_gap(n);
        chk(n == 7, "R3 length seven", n, 7);

        // random phase checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            mod_bit  = 1'($urandom % 2);
            sync_cmd = ($urandom % 40) == 0;
            chan_chg = ($urandom % 60) == 0;
            if (($urandom % 50) == 0) sync_pin = ~sync_pin;
            if (($urandom % 200) == 0) conv_len = LEN_W'($urandom % 8);
            tick(1);
        end
        sync_cmd = 1'b0;
        chan_chg = 1'b0;
        sync_pin = 1'b0;
        tick(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule